// File: doc/BRIEF.md
# Routable Two-Bank Interrupt Steering Unit

This block gathers thirty-two level-sensitive interrupt sources, arranged as two banks of sixteen, and presents them to a processor on five interrupt lines. Each source input passes through a two-flop synchroniser into a read-only pending word. A per-bank enable word gates it. A 3-bit routing field then picks which of the five lines the source drives. Each line is the OR of every enabled, pending source routed to it.

A host reaches the block through a 16-bit register port with two address windows. Window A holds bank A's pending, enable and routing words, and also the two routing words for bank B. Window B holds only bank B's pending and enable words. Writes take effect on the clock edge that samples them. Reads are combinational from registered state. Software is expected to clear both enable words after reset and to change routing by read-modify-write of whole words. Field values above 4 are refused field by field.

Top module: `irq_steer_unit`

## Requirements
- R1: After reset both pending words and both enable words read 0, cpu_irq is 0, and the routing words read: A0 = 0x0040 (bank A source 2 to line 1), A1 = 0x0000, B0 = 0x0002 (bank B source 0 to line 2), B1 = 0x0000.
- R2: A pending bit equals its source input as sampled two rising clock edges earlier. It rises when the input rises and clears only when the input falls.
- R3: The enable words are read/write, with a 1 enabling the source. Bank A's is at window A word 6 (byte 0x0C) and bank B's is at window B word 3 (byte 0x06).
- R4: cpu_irq[k] is 1 exactly when some source in either bank is pending, enabled and routed to line k.
- R5: Routing fields are 3 bits wide at bit positions [2:0], [5:3], [8:6], [11:9] and [14:12], numbered fields 0 to 4. The words sit in window A:
  - A0 at word 2 (byte 0x04) holds bank A sources 0 to 4 in fields 0 to 4.
  - A1 at word 3 (byte 0x06) holds bank A source 5 in field 0, source 6 in field 2 and source 7 in field 3.
  - B0 at word 14 (byte 0x1C) holds bank B sources 0 to 4.
  - B1 at word 15 (byte 0x1E) holds bank B sources 5 to 9.
- R6: Within a routing write, any field whose value exceeds 4 keeps its previous value. Fields of the same write with values 0 to 4 are still stored.
- R7: Routing bits with no field, bit 15 and A1 bits [5:3] and [14:12], always read 0. Word addresses with no register read 0.
- R8: Bank A sources 8 to 15 and bank B sources 10 to 15 always drive line 0 when pending and enabled.
- R9: A write to a pending word (word 0 of either window) has no effect on what the pending word reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_a | input | 16 | Bank A interrupt levels, asynchronous |
| src_b | input | 16 | Bank B interrupt levels, asynchronous |
| win_b | input | 1 | Window select: 0 = window A, 1 = window B |
| word_addr | input | 4 | 16-bit word index inside the window (byte offset / 2) |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for win_b / word_addr, combinational |
| cpu_irq | output | 5 | Processor interrupt lines 0 to 4 |

## Verification
A host write to a routing or enable word can land in the same cycle as a source edge that is still in the synchroniser. The line state then depends on both events. The bench sets a source active and enabled on line 0. In one cycle it both drops the source and rewrites the source's routing field to 4. The line must move to line 4 after the first edge, while the stale pending bit is still high, and must fall to zero one edge later. A second case turns off an enable bit in the same cycle that a new source level is driven, and requires that no line ever rises.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

    localparam int NSRC   = 16;
    localparam int NLINE  = 5;
    localparam int FW     = 3;
    localparam int NFIELD = 5;
    localparam int DW     = 16;
    localparam int WAW    = 4;
    localparam int MAXRT  = NLINE - 1;

    // word indices (byte offset / 2)
    localparam logic [WAW-1:0] W_PEND   = 4'd0;
    localparam logic [WAW-1:0] W_RT_A0  = 4'd2;
    localparam logic [WAW-1:0] W_RT_A1  = 4'd3;
    localparam logic [WAW-1:0] W_EN_A   = 4'd6;
    localparam logic [WAW-1:0] W_RT_B0  = 4'd14;
    localparam logic [WAW-1:0] W_RT_B1  = 4'd15;
    localparam logic [WAW-1:0] W_EN_B   = 4'd3;

    // populated fields of each routing word
    localparam logic [NFIELD-1:0] POP_FULL = 5'b11111;
    localparam logic [NFIELD-1:0] POP_A1   = 5'b01101;

    localparam logic [DW-1:0] RST_RT_A0 = DW'(1) << (2 * FW);
    localparam logic [DW-1:0] RST_RT_B0 = DW'(2);

    typedef struct packed {
        logic [DW-1:0] en_a;
        logic [DW-1:0] en_b;
        logic [DW-1:0] rt_a0;
        logic [DW-1:0] rt_a1;
        logic [DW-1:0] rt_b0;
        logic [DW-1:0] rt_b1;
    } steer_state_t;

    function automatic logic [FW-1:0] get_field(logic [DW-1:0] w, int f);
        return w[f*FW +: FW];
    endfunction

    // store only populated fields holding a legal line number
    function automatic logic [DW-1:0] route_update(logic [DW-1:0] old_w,
                                                   logic [DW-1:0] wd,
                                                   logic [NFIELD-1:0] pop);
        logic [DW-1:0] r;
        r = old_w;
        for (int f = 0; f < NFIELD; f++) begin
            if (pop[f] && (wd[f*FW +: FW] <= FW'(MAXRT)))
                r[f*FW +: FW] = wd[f*FW +: FW];
        end
        return r;
    endfunction

    function automatic logic [FW-1:0] route_of_a(int s, logic [DW-1:0] w0,
                                                 logic [DW-1:0] w1);
        if (s < NFIELD) return get_field(w0, s);
        else if (s == 5) return get_field(w1, 0);
        else if (s == 6) return get_field(w1, 2);
        else if (s == 7) return get_field(w1, 3);
        else return '0;
    endfunction

    function automatic logic [FW-1:0] route_of_b(int s, logic [DW-1:0] w0,
                                                 logic [DW-1:0] w1);
        if (s < NFIELD) return get_field(w0, s);
        else if (s < 2 * NFIELD) return get_field(w1, s - NFIELD);
        else return '0;
    endfunction

endpackage

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_in,
    output logic [W-1:0] lvl_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.meta   = lvl_in;
        sy_d.stable = sy_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign lvl_out = sy_q.stable;
endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge
    import irq_steer_pkg::*;
(
    input  logic [NSRC-1:0]  pend_a,
    input  logic [NSRC-1:0]  pend_b,
    input  logic [NSRC-1:0]  en_a,
    input  logic [NSRC-1:0]  en_b,
    input  logic [DW-1:0]    rt_a0,
    input  logic [DW-1:0]    rt_a1,
    input  logic [DW-1:0]    rt_b0,
    input  logic [DW-1:0]    rt_b1,
    output logic [NLINE-1:0] lines
);
    logic [FW-1:0]   sel_a [NSRC];
    logic [FW-1:0]   sel_b [NSRC];
    logic [NSRC-1:0] live_a, live_b;

    assign live_a = pend_a & en_a;
    assign live_b = pend_b & en_b;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign sel_a[s] = route_of_a(s, rt_a0, rt_a1);
        assign sel_b[s] = route_of_b(s, rt_b0, rt_b1);
    end

    for (genvar k = 0; k < NLINE; k++) begin : g_line
        logic [NSRC-1:0] hit_a, hit_b;
        for (genvar s = 0; s < NSRC; s++) begin : g_hit
            assign hit_a[s] = live_a[s] && (sel_a[s] == FW'(k));
            assign hit_b[s] = live_b[s] && (sel_b[s] == FW'(k));
        end
        assign lines[k] = |{hit_a, hit_b};
    end
endmodule

// File: rtl/irq_steer_unit.sv
module irq_steer_unit
    import irq_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_a,
    input  logic [NSRC-1:0]  src_b,
    input  logic             win_b,
    input  logic [WAW-1:0]   word_addr,
    input  logic             wr_en,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic [NLINE-1:0] cpu_irq
);
    logic [NSRC-1:0] pend_a, pend_b;
    steer_state_t    st_d, st_q;

    irq_level_sync #(.W(NSRC)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .lvl_in(src_a), .lvl_out(pend_a)
    );
    irq_level_sync #(.W(NSRC)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .lvl_in(src_b), .lvl_out(pend_b)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en && !win_b) begin
            unique case (word_addr)
                W_EN_A:  st_d.en_a  = wdata;
                W_RT_A0: st_d.rt_a0 = route_update(st_q.rt_a0, wdata, POP_FULL);
                W_RT_A1: st_d.rt_a1 = route_update(st_q.rt_a1, wdata, POP_A1);
                W_RT_B0: st_d.rt_b0 = route_update(st_q.rt_b0, wdata, POP_FULL);
                W_RT_B1: st_d.rt_b1 = route_update(st_q.rt_b1, wdata, POP_FULL);
                default: ;
            endcase
        end else if (wr_en && win_b && word_addr == W_EN_B) begin
            st_d.en_b = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.rt_a0 <= RST_RT_A0;
            st_q.rt_b0 <= RST_RT_B0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (!win_b) begin
            unique case (word_addr)
                W_PEND:  rdata = pend_a;
                W_EN_A:  rdata = st_q.en_a;
                W_RT_A0: rdata = st_q.rt_a0;
                W_RT_A1: rdata = st_q.rt_a1;
                W_RT_B0: rdata = st_q.rt_b0;
                W_RT_B1: rdata = st_q.rt_b1;
                default: rdata = '0;
            endcase
        end else begin
            unique case (word_addr)
                W_PEND:  rdata = pend_b;
                W_EN_B:  rdata = st_q.en_b;
                default: rdata = '0;
            endcase
        end
    end

    irq_line_merge u_merge (
        .pend_a(pend_a), .pend_b(pend_b),
        .en_a(st_q.en_a), .en_b(st_q.en_b),
        .rt_a0(st_q.rt_a0), .rt_a1(st_q.rt_a1),
        .rt_b0(st_q.rt_b0), .rt_b1(st_q.rt_b1),
        .lines(cpu_irq)
    );
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk
    import irq_steer_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  src_a,
    input logic [NSRC-1:0]  src_b,
    input logic [NSRC-1:0]  pend_a,
    input logic [NSRC-1:0]  pend_b,
    input logic [DW-1:0]    en_a,
    input logic [DW-1:0]    en_b,
    input logic [DW-1:0]    rt_a0,
    input logic             win_b,
    input logic [WAW-1:0]   word_addr,
    input logic             wr_en,
    input logic [DW-1:0]    wdata,
    input logic [NLINE-1:0] cpu_irq
);
    logic [1:0] warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    assert_pend_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (pend_a == $past(src_a, 2) && pend_b == $past(src_b, 2)));

    assert_line_needs_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq != '0) |-> (((pend_a & en_a) | (pend_b & en_b)) != '0));

    assert_enable_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !win_b && word_addr == W_EN_A) |=> (en_a == $past(wdata)));

    assert_enable_b_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && win_b && word_addr == W_EN_B) |=> (en_b == $past(wdata)));

    assert_bad_field_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !win_b && word_addr == W_RT_A0 && wdata[2:0] > 3'd4)
        |=> (rt_a0[2:0] == $past(rt_a0[2:0])));

    assert_line_onehot_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones((pend_a & en_a)) + $countones((pend_b & en_b)) == 1)
        |-> $onehot0(cpu_irq) && cpu_irq != '0);
endmodule

bind irq_steer_unit irq_steer_chk chk_i (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
    .pend_a(pend_a), .pend_b(pend_b),
    .en_a(st_q.en_a), .en_b(st_q.en_b), .rt_a0(st_q.rt_a0),
    .win_b(win_b), .word_addr(word_addr), .wr_en(wr_en), .wdata(wdata),
    .cpu_irq(cpu_irq)
);

// File: tb/irq_steer_unit_tb_top.sv
module irq_steer_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_a = '0, src_b = '0;
    logic        win_b = 1'b0;
    logic [3:0]  word_addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [4:0]  cpu_irq;

    int checks = 0;
    int errors = 0;
    int m_rt_a [16];
    int m_rt_b [16];
    logic [15:0] m_en_a, m_en_b;

    always #2ns clk = ~clk;

    irq_steer_unit dut_i (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .win_b(win_b), .word_addr(word_addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .cpu_irq(cpu_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic wb, input logic [3:0] wa, input logic [15:0] d);
        @(negedge clk);
        win_b = wb; word_addr = wa; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic wb, input logic [3:0] wa, output logic [15:0] d);
        win_b = wb; word_addr = wa;
        #1ns;
        d = rdata;
    endtask

    // bench model of the routing map (R5, R6)
    function automatic int rt_src(input int wsel, input int f);
        if (wsel == 0) return f;
        if (wsel == 1) return (f == 0) ? 5 : (f == 2) ? 6 : (f == 3) ? 7 : -1;
        if (wsel == 2) return f;
        return f + 5;
    endfunction

    task automatic model_rt_wr(input int wsel, input logic [15:0] d);
        for (int f = 0; f < 5; f++) begin
            int s = rt_src(wsel, f);
            int v = int'(d[f*3 +: 3]);
            if (s >= 0 && v <= 4) begin
                if (wsel < 2) m_rt_a[s] = v; else m_rt_b[s] = v;
            end
        end
    endtask

    function automatic logic [15:0] model_rt_word(input int wsel);
        logic [15:0] w = '0;
        for (int f = 0; f < 5; f++) begin
            int s = rt_src(wsel, f);
            if (s >= 0) w[f*3 +: 3] = 3'((wsel < 2) ? m_rt_a[s] : m_rt_b[s]);
        end
        return w;
    endfunction

    function automatic logic [4:0] model_irq();
        logic [4:0] r = '0;
        for (int s = 0; s < 16; s++) begin
            if (src_a[s] && m_en_a[s]) r[m_rt_a[s]] = 1'b1;
            if (src_b[s] && m_en_b[s]) r[m_rt_b[s]] = 1'b1;
        end
        return r;
    endfunction

    task automatic settle_src(input logic [15:0] a, input logic [15:0] b);
        @(negedge clk); src_a = a; src_b = b;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        host_rd(0, 4'd0, d);  chk("R1 pend A", d, 16'h0000);
        host_rd(1, 4'd0, d);  chk("R1 pend B", d, 16'h0000);
        host_rd(0, 4'd6, d);  chk("R1 enable A", d, 16'h0000);
        host_rd(1, 4'd3, d);  chk("R1 enable B", d, 16'h0000);
        host_rd(0, 4'd2, d);  chk("R1 route A0", d, 16'h0040);
        host_rd(0, 4'd3, d);  chk("R1 route A1", d, 16'h0000);
        host_rd(0, 4'd14, d); chk("R1 route B0", d, 16'h0002);
        host_rd(0, 4'd15, d); chk("R1 route B1", d, 16'h0000);
        chk("R1 cpu_irq", 16'(cpu_irq), 16'h0000);
    endtask

    task automatic t_pending();
        logic [15:0] d;
        @(negedge clk); src_a = 16'h00A5; src_b = 16'h8001;
        @(negedge clk);
        host_rd(0, 4'd0, d); chk("R2 pend A one edge", d, 16'h0000);
        @(negedge clk);
        host_rd(0, 4'd0, d); chk("R2 pend A two edges", d, 16'h00A5);
        host_rd(1, 4'd0, d); chk("R2 pend B two edges", d, 16'h8001);
        chk("R4 masked sources give no line", 16'(cpu_irq), 16'h0000);
        settle_src(16'h0000, 16'h0000);
        host_rd(0, 4'd0, d); chk("R2 pend A clears", d, 16'h0000);
    endtask

    task automatic t_enable();
        logic [15:0] d;
        host_wr(0, 4'd6, 16'hFFFF); m_en_a = 16'hFFFF;
        host_rd(0, 4'd6, d); chk("R3 enable A readback", d, 16'hFFFF);
        host_wr(1, 4'd3, 16'h1234); m_en_b = 16'h1234;
        host_rd(1, 4'd3, d); chk("R3 enable B readback", d, 16'h1234);
        host_wr(1, 4'd3, 16'hFFFF); m_en_b = 16'hFFFF;
    endtask

    task automatic t_default_routes();
        settle_src(16'h0004, 16'h0000);
        chk("R4 A src2 default line 1", 16'(cpu_irq), 16'h0002);
        settle_src(16'h0004, 16'h0001);
        chk("R4 A src2 + B src0", 16'(cpu_irq), 16'(model_irq()));
        settle_src(16'h0400, 16'h1000);
        chk("R8 fixed sources on line 0", 16'(cpu_irq), 16'h0001);
        settle_src(16'h0000, 16'h0000);
    endtask

    task automatic t_route_write();
        logic [15:0] d;
        host_wr(0, 4'd3, 16'h053B); model_rt_wr(1, 16'h053B);
        host_rd(0, 4'd3, d); chk("R7 A1 unpopulated bits read 0", d, 16'h0503);
        chk("R5 A1 model", d, model_rt_word(1));
        settle_src(16'h0020, 16'h0000);
        chk("R5 A src5 to line 3", 16'(cpu_irq), 16'h0008);
        settle_src(16'h0040, 16'h0000);
        chk("R5 A src6 to line 4", 16'(cpu_irq), 16'h0010);
        settle_src(16'h0080, 16'h0000);
        chk("R5 A src7 to line 2", 16'(cpu_irq), 16'h0004);
        host_wr(0, 4'd15, 16'h3000); model_rt_wr(3, 16'h3000);
        settle_src(16'h0000, 16'h0200);
        chk("R5 B src9 to line 3", 16'(cpu_irq), 16'h0008);
        settle_src(16'h0000, 16'h0000);
    endtask

    task automatic t_illegal();
        logic [15:0] d;
        host_wr(0, 4'd2, 16'h7055); model_rt_wr(0, 16'h7055);
        host_rd(0, 4'd2, d); chk("R6 bad fields kept, good stored", d, 16'h0050);
        host_wr(0, 4'd14, 16'hFFFF); model_rt_wr(2, 16'hFFFF);
        host_rd(0, 4'd14, d); chk("R6 all-bad write leaves B0", d, 16'h0002);
        settle_src(16'h0002, 16'h0000);
        chk("R6 A src1 on line 2", 16'(cpu_irq), 16'h0004);
        settle_src(16'h0000, 16'h0000);
    endtask

    task automatic t_readonly();
        logic [15:0] d;
        host_wr(0, 4'd0, 16'hFFFF);
        host_wr(1, 4'd0, 16'hFFFF);
        host_rd(0, 4'd0, d); chk("R9 pend A ignores write", d, 16'h0000);
        host_rd(1, 4'd0, d); chk("R9 pend B ignores write", d, 16'h0000);
        host_rd(0, 4'd8, d); chk("R7 unmapped A word reads 0", d, 16'h0000);
        host_rd(1, 4'd6, d); chk("R7 window B has no enable at word 6", d, 16'h0000);
    endtask

    task automatic t_collision();
        logic [15:0] d;
        settle_src(16'h0008, 16'h0000);
        chk("R4 A src3 on line 0", 16'(cpu_irq), 16'h0001);
        d = model_rt_word(0);
        d[11:9] = 3'd4;
        @(negedge clk);
        src_a = 16'h0000; win_b = 0; word_addr = 4'd2; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_rt_wr(0, d);
        #1ns chk("R4 rerouted while stale pending", 16'(cpu_irq), 16'h0010);
        @(negedge clk);
        #1ns chk("R2 line drops after sync", 16'(cpu_irq), 16'h0000);
        @(negedge clk);
        src_a = 16'h1000; win_b = 0; word_addr = 4'd6; wdata = 16'hEFFF; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; m_en_a = 16'hEFFF;
        chk("R3 disable before pending arrives", 16'(cpu_irq), 16'h0000);
        @(negedge clk); @(negedge clk);
        chk("R3 disabled source stays silent", 16'(cpu_irq), 16'h0000);
        src_a = 16'h0000;
    endtask

    initial begin
        for (int s = 0; s < 16; s++) begin m_rt_a[s] = 0; m_rt_b[s] = 0; end
        m_rt_a[2] = 1; m_rt_b[0] = 2;
        m_en_a = '0; m_en_b = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pending();
        t_enable();
        t_default_routes();
        t_route_write();
        t_illegal();
        t_readonly();
        t_collision();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200us;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule